// File: doc/BRIEF.md
# Downlink NRZ Frame Decoder

This block turns a one-bit downlink sample stream into bytes. The stream carries NRZ-coded characters at four samples per bit period. A qualifier strobe marks which clock cycles carry a sample. The decoder first looks for a start-of-frame marker, which is a low run of a bounded length followed by a rise. It then collects 10-bit characters and writes each data byte to an external buffer through a simple write port that carries data, index and strobe.

A frame ends when a character made entirely of zeros arrives. At that point the block pulses a completion flag together with the byte count. Any timing or framing violation drops the decoder back to the hunting state. Nothing is reported when this happens, and the next frame is searched for from scratch. A level output marks the time from a qualified start-of-frame until the decoder leaves the frame, so that a neighbouring decoder can be held off while a frame is in progress.

Top module: `nrzb_frame_rx`

## Requirements
- R1: Synchronous active-low reset clears all state, even in the middle of a frame. While reset is held and in the first cycle after it, byte_stb, frm_done and frm_active are 0.
- R2: Only cycles with smp_vld=1 advance the decoder. Each group of four valid samples is one bit period. The bit value is taken from the third sample of the group, and the other three samples have no effect on a bit inside a character.
- R3: In the hunting state, a low sample starts a start-of-frame measurement, and that sample is phase 0 of the first low bit. If the first high bit comes after 10, 11 or 12 low bit periods, the start-of-frame is accepted. If it comes after 9 or fewer, the decoder returns to hunting.
- R4: A 13th consecutive low bit period during the measurement abandons it, and no frame is decoded from that run.
- R5: After an accepted start-of-frame or an accepted character, the decoder waits for a low sample, which begins the next character. Up to 25 consecutive high samples are tolerated. The 26th returns the decoder to hunting.
- R6: A character is 10 bits, received least significant bit first. It is a data character when bit 0 (start) is 0 and bit 9 (stop) is 1, and its byte is bits 1 to 8, with bit 1 as the byte's LSB. Each data byte gives a one-cycle byte_stb with byte_val and byte_idx. byte_idx counts from 0 within the frame.
- R7: A character whose 10 bits are all 0 ends the frame. If at least one byte was received, it gives a one-cycle frm_done with frm_len equal to the byte count. If no byte was received, it gives no pulse. The decoder returns to hunting in both cases.
- R8: A character that is neither data nor all-zero returns the decoder to hunting, with no byte write and no completion pulse.
- R9: When the byte with index MAX_BYTES-1 is written, the decoder returns to hunting. It produces no completion pulse for that frame.
- R10: frm_active is 1 exactly while the decoder is waiting for a character or receiving one, that is, from an accepted start-of-frame until it returns to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Marks a cycle that carries a sample |
| smp_bit | input | 1 | Downlink sample value |
| byte_stb | output | 1 | One-cycle write strobe for a received byte |
| byte_val | output | 8 | Received byte |
| byte_idx | output | $clog2(MAX_BYTES) (8) | Position of the byte within the frame |
| frm_done | output | 1 | One-cycle end-of-frame pulse |
| frm_len | output | $clog2(MAX_BYTES+1) (9) | Bytes in the completed frame |
| frm_active | output | 1 | Decoder is inside a qualified frame |

## Verification
The embedded properties assume an ideally sampled stream: exactly four valid samples per bit, with no jitter that would slip a bit period. They also assume that reset is the only event that disturbs the sample phase. The stimulus therefore builds every bit from four samples. The only perturbations it applies are idle cycles with smp_vld low between samples and inverted values on the non-decision samples of data bits. It never drops or adds a valid sample inside a bit. The stop bit and the first sample of each start bit are always clean, so a glitch cannot be mistaken for the start of a new character.

// File: rtl/nrzb_pkg.sv
// Package nrzb_pkg
// Holds the decoder state encoding shared by the control and top modules.
// Assumes nothing; contains types only.
package nrzb_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,   // no frame, waiting for a low sample
        ST_SOFL = 2'd1,   // measuring the start-of-frame low run
        ST_GAP  = 2'd2,   // between characters, waiting for a start bit
        ST_CHAR = 2'd3    // shifting in a character
    } nrzb_state_e;

endpackage

// File: rtl/nrzb_phase.sv
// Module nrzb_phase
// Tracks the sample phase inside a bit period and flags the decision sample.
// Assumes restart is asserted on the sample that is phase 0 of a new bit,
// and that restart never depends on the mid output (no combinational loop).
module nrzb_phase #(
    parameter int SPB = 4,   // samples per bit period
    parameter int MID = 2    // phase index of the decision sample
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic restart,
    output logic mid
);
    localparam int PW = (SPB > 1) ? $clog2(SPB) : 1;

    logic [PW-1:0] ph;   // phase of the next valid sample

    // Phase counter: reload on restart, otherwise wrap every SPB samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (smp_vld) begin
            if (restart)
                ph <= PW'(1);
            else if (ph == PW'(SPB - 1))
                ph <= '0;
            else
                ph <= ph + PW'(1);
        end
    end

    // Decision strobe for the current sample.
    always_comb mid = smp_vld && !restart && (ph == PW'(MID));

    // Two decision samples can never sit in adjacent cycles.
    AST_MID_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        mid |=> !mid);  // R2

endmodule

// File: rtl/nrzb_shift.sv
// Module nrzb_shift
// Collects one character, least significant bit first, and flags the last bit.
// Assumes clear arrives before the first take of each character.
module nrzb_shift #(
    parameter int CHW = 10   // bits per character
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           take,
    input  logic           bit_in,
    output logic [CHW-1:0] word_nxt,
    output logic           last
);
    localparam int CNTW = $clog2(CHW + 1);

    logic [CHW-1:0]  word;
    logic [CNTW-1:0] cnt;

    // Next word with the new bit entering at the top (LSB first on the line).
    always_comb word_nxt = {bit_in, word[CHW-1:1]};

    // Final bit of the character is being taken this cycle.
    always_comb last = take && (cnt == CNTW'(CHW - 1));

    // Shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word <= '0;
            cnt  <= '0;
        end else if (take) begin
            word <= word_nxt;
            cnt  <= cnt + CNTW'(1);
        end
    end

    // A fresh character never starts already complete.
    AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !last);  // R6

endmodule

// File: rtl/nrzb_ctrl.sv
// Module nrzb_ctrl
// Frame state machine: start-of-frame qualification, inter-character timeout,
// character classification, byte writes and end-of-frame reporting.
// Assumes mid marks the decision sample and word/last come from nrzb_shift.
module nrzb_ctrl
    import nrzb_pkg::*;
#(
    parameter int CHW       = 10,
    parameter int SOF_MIN   = 10,
    parameter int SOF_MAX   = 12,
    parameter int IDLE_MAX  = 25,
    parameter int MAX_BYTES = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_vld,
    input  logic                         smp_bit,
    input  logic                         mid,
    input  logic                         chr_last,
    input  logic [CHW-1:0]               chr_word,
    output logic                         restart,
    output logic                         sh_take,
    output logic                         byte_stb,
    output logic [CHW-3:0]               byte_val,
    output logic [$clog2(MAX_BYTES)-1:0] byte_idx,
    output logic                         frm_done,
    output logic [$clog2(MAX_BYTES+1)-1:0] frm_len,
    output logic                         frm_active
);
    localparam int DW  = CHW - 2;
    localparam int IW  = $clog2(MAX_BYTES);
    localparam int BW  = $clog2(MAX_BYTES + 1);
    localparam int LW  = $clog2(SOF_MAX + 2);
    localparam int QW  = $clog2(IDLE_MAX + 2);

    nrzb_state_e st, st_n;
    logic [LW-1:0] low, low_n;
    logic [QW-1:0] idle, idle_n;
    logic [BW-1:0] nb, nb_n;
    logic          wr_n, done_n;
    logic [DW-1:0] val_n;
    logic [IW-1:0] idx_n;
    logic [BW-1:0] len_n;

    // A low sample while hunting or waiting starts a new bit period.
    always_comb restart = smp_vld && !smp_bit && (st == ST_HUNT || st == ST_GAP);

    // Character bits are taken on decision samples only.
    always_comb sh_take = mid && (st == ST_CHAR);

    // Next-state and output decode for one sample.
    always_comb begin
        st_n   = st;
        low_n  = low;
        idle_n = idle;
        nb_n   = nb;
        wr_n   = 1'b0;
        done_n = 1'b0;
        val_n  = byte_val;
        idx_n  = byte_idx;
        len_n  = frm_len;
        case (st)
            ST_HUNT: begin
                if (smp_vld && !smp_bit) begin
                    st_n  = ST_SOFL;
                    low_n = '0;
                    nb_n  = '0;
                end
            end
            ST_SOFL: begin
                if (mid) begin
                    if (smp_bit) begin
                        if (low >= LW'(SOF_MIN)) begin
                            st_n   = ST_GAP;
                            idle_n = '0;
                        end else begin
                            st_n = ST_HUNT;
                        end
                    end else if (low == LW'(SOF_MAX)) begin
                        st_n = ST_HUNT;
                    end else begin
                        low_n = low + LW'(1);
                    end
                end
            end
            ST_GAP: begin
                if (smp_vld) begin
                    if (!smp_bit)
                        st_n = ST_CHAR;
                    else if (idle == QW'(IDLE_MAX))
                        st_n = ST_HUNT;
                    else
                        idle_n = idle + QW'(1);
                end
            end
            ST_CHAR: begin
                if (chr_last) begin
                    if (chr_word[CHW-1] && !chr_word[0]) begin
                        wr_n  = 1'b1;
                        val_n = chr_word[CHW-2:1];
                        idx_n = nb[IW-1:0];
                        nb_n  = nb + BW'(1);
                        if (nb == BW'(MAX_BYTES - 1)) begin
                            st_n = ST_HUNT;
                        end else begin
                            st_n   = ST_GAP;
                            idle_n = '0;
                        end
                    end else if (chr_word == '0) begin
                        st_n = ST_HUNT;
                        if (nb != '0) begin
                            done_n = 1'b1;
                            len_n  = nb;
                        end
                    end else begin
                        st_n = ST_HUNT;
                    end
                end
            end
            default: st_n = ST_HUNT;
        endcase
    end

    // State, counters and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_HUNT;
            low      <= '0;
            idle     <= '0;
            nb       <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
            byte_idx <= '0;
            frm_done <= 1'b0;
            frm_len  <= '0;
        end else begin
            st       <= st_n;
            low      <= low_n;
            idle     <= idle_n;
            nb       <= nb_n;
            byte_stb <= wr_n;
            byte_val <= val_n;
            byte_idx <= idx_n;
            frm_done <= done_n;
            frm_len  <= len_n;
        end
    end

    // Activity level follows the in-frame states.
    always_comb frm_active = (st == ST_GAP) || (st == ST_CHAR);

    AST_SOF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SOFL) |-> (low <= LW'(SOF_MAX)));  // R4
    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |-> (idle <= QW'(IDLE_MAX)));  // R5
    AST_WRITE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && byte_idx != IW'(MAX_BYTES - 1)) |-> frm_active);  // R6
    AST_DONE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> (frm_len != '0 && !frm_active));  // R7
    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_stb && frm_done));  // R8
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && byte_idx == IW'(MAX_BYTES - 1)) |-> !frm_active);  // R9

endmodule

// File: rtl/nrzb_frame_rx.sv
// Module nrzb_frame_rx
// Top of the downlink NRZ frame decoder: phase tracking, character shifter
// and frame control. Assumes a sample stream at SMP_PER_BIT samples per bit.
module nrzb_frame_rx #(
    parameter int MAX_BYTES   = 256,
    parameter int SMP_PER_BIT = 4,
    parameter int MID_PHASE   = 2,
    parameter int DATA_W      = 8,
    parameter int SOF_MIN     = 10,
    parameter int SOF_MAX     = 12,
    parameter int IDLE_MAX    = 25
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           smp_vld,
    input  logic                           smp_bit,
    output logic                           byte_stb,
    output logic [DATA_W-1:0]              byte_val,
    output logic [$clog2(MAX_BYTES)-1:0]   byte_idx,
    output logic                           frm_done,
    output logic [$clog2(MAX_BYTES+1)-1:0] frm_len,
    output logic                           frm_active
);
    localparam int CHW = DATA_W + 2;

    logic           restart;
    logic           mid;
    logic           sh_take;
    logic           chr_last;
    logic [CHW-1:0] chr_word;

    nrzb_phase #(.SPB(SMP_PER_BIT), .MID(MID_PHASE)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .restart (restart),
        .mid     (mid)
    );

    nrzb_shift #(.CHW(CHW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .take     (sh_take),
        .bit_in   (smp_bit),
        .word_nxt (chr_word),
        .last     (chr_last)
    );

    nrzb_ctrl #(
        .CHW       (CHW),
        .SOF_MIN   (SOF_MIN),
        .SOF_MAX   (SOF_MAX),
        .IDLE_MAX  (IDLE_MAX),
        .MAX_BYTES (MAX_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld    (smp_vld),
        .smp_bit    (smp_bit),
        .mid        (mid),
        .chr_last   (chr_last),
        .chr_word   (chr_word),
        .restart    (restart),
        .sh_take    (sh_take),
        .byte_stb   (byte_stb),
        .byte_val   (byte_val),
        .byte_idx   (byte_idx),
        .frm_done   (frm_done),
        .frm_len    (frm_len),
        .frm_active (frm_active)
    );

endmodule

// File: tb/sim_nrzb_frame_rx.sv
module sim_nrzb_frame_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic       smp_bit = 1'b1;
    logic       byte_stb;
    logic [7:0] byte_val;
    logic [7:0] byte_idx;
    logic       frm_done;
    logic [8:0] frm_len;
    logic       frm_active;

    int    checks = 0;
    int    errs = 0;
    bit    gap_mode = 0;
    bit    glitch = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    int    q_kind[$];
    int    q_val[$];
    int    q_idx[$];
    string q_tag[$];

    always #4 clk = ~clk;

    nrzb_frame_rx u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_bit(smp_bit),
        .byte_stb(byte_stb), .byte_val(byte_val), .byte_idx(byte_idx),
        .frm_done(frm_done), .frm_len(frm_len), .frm_active(frm_active)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Scoreboard driver side
    task automatic push_byte(input int v, input int idx, input string tag);
        q_kind.push_back(1); q_val.push_back(v); q_idx.push_back(idx); q_tag.push_back(tag);
    endtask
    task automatic push_done(input int len, input string tag);
        q_kind.push_back(2); q_val.push_back(len); q_idx.push_back(0); q_tag.push_back(tag);
    endtask

    // Monitor: pops expected events as the design produces them
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (byte_stb) begin
                if (q_kind.size() == 0) begin
                    chk(0, cur_tag, int'(byte_val), -1, "unexpected byte write");
                end else begin
                    chk(q_kind[0] == 1, q_tag[0], 1, q_kind[0], "event kind (1=byte)");
                    chk(int'(byte_val) == q_val[0], q_tag[0], int'(byte_val), q_val[0], "byte value");
                    chk(int'(byte_idx) == q_idx[0], q_tag[0], int'(byte_idx), q_idx[0], "byte index");
                    void'(q_kind.pop_front()); void'(q_val.pop_front());
                    void'(q_idx.pop_front()); void'(q_tag.pop_front());
                end
            end
            if (frm_done) begin
                if (q_kind.size() == 0) begin
                    chk(0, cur_tag, int'(frm_len), -1, "unexpected frame done");
                end else begin
                    chk(q_kind[0] == 2, q_tag[0], 2, q_kind[0], "event kind (2=done)");
                    chk(int'(frm_len) == q_val[0], q_tag[0], int'(frm_len), q_val[0], "frame length");
                    void'(q_kind.pop_front()); void'(q_val.pop_front());
                    void'(q_idx.pop_front()); void'(q_tag.pop_front());
                end
            end
        end
    end

    task automatic smp1(input logic b);
        @(negedge clk);
        smp_vld = 1'b1;
        smp_bit = b;
        if (gap_mode) begin
            @(negedge clk);
            smp_vld = 1'b0;
            smp_bit = ~b;
        end
    endtask

    task automatic bitp(input logic b, input bit may_glitch);
        for (int p = 0; p < 4; p++)
            smp1((glitch && may_glitch && p != 2) ? ~b : b);
    endtask

    // n low bits, then high samples up to the decision sample
    task automatic sof(input int n);
        for (int i = 0; i < n; i++) bitp(1'b0, 0);
        repeat (3) smp1(1'b1);
    endtask

    task automatic chr(input logic [7:0] d, input logic stop);
        bitp(1'b0, 0);
        for (int i = 0; i < 8; i++) bitp(d[i], 1);
        bitp(stop, 0);
    endtask

    task automatic eof();
        for (int i = 0; i < 10; i++) bitp(1'b0, 0);
    endtask

    task automatic settle();
        repeat (40) smp1(1'b1);
    endtask

    task automatic check_active(input logic exp, input string tag);
        @(negedge clk);
        smp_vld = 1'b0;
        chk(frm_active === exp, tag, int'(frm_active), int'(exp), "frm_active");
    endtask

    task automatic frame3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input string tag);
        cur_tag = tag;
        settle();
        sof(10);
        repeat (5) smp1(1'b1);
        push_byte(a, 0, tag); chr(a, 1'b1);
        push_byte(b, 1, tag); chr(b, 1'b1);
        push_byte(c, 2, tag); chr(c, 1'b1);
        push_done(3, tag);
        eof();
        settle();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs during reset
        chk(byte_stb === 1'b0 && frm_done === 1'b0 && frm_active === 1'b0, "R1", int'(frm_active), 0, "outputs in reset");
        rst_n = 1'b1;
        check_active(1'b0, "R1");

        // R6 and R10: plain frame, activity over its course
        cur_tag = "R10";
        settle();
        sof(10);
        check_active(1'b1, "R10");
        repeat (4) smp1(1'b1);
        push_byte(8'h3C, 0, "R6"); chr(8'h3C, 1'b1);
        check_active(1'b1, "R10");
        push_byte(8'hA5, 1, "R6"); chr(8'hA5, 1'b1);
        push_byte(8'h01, 2, "R6"); chr(8'h01, 1'b1);
        push_done(3, "R7");
        eof();
        check_active(1'b0, "R10");
        settle();

        // R2: idle cycles between samples, then glitches off the decision sample
        gap_mode = 1;
        frame3(8'h5A, 8'hFF, 8'h80, "R2");
        gap_mode = 0;
        glitch = 1;
        frame3(8'h96, 8'h00, 8'h81, "R2");
        glitch = 0;

        // R3: 9 low periods rejected, 12 accepted
        cur_tag = "R3";
        settle();
        sof(9);
        check_active(1'b0, "R3");
        settle();
        sof(12);
        check_active(1'b1, "R3");
        repeat (2) smp1(1'b1);
        push_byte(8'hC3, 0, "R3"); chr(8'hC3, 1'b1);
        push_done(1, "R3");
        eof();
        settle();

        // R4: 13 low periods abandon the measurement
        cur_tag = "R4";
        sof(13);
        check_active(1'b0, "R4");
        settle();
        check_active(1'b0, "R4");

        // R5: 25 idle samples tolerated, 26 drop
        cur_tag = "R5";
        sof(10);
        repeat (25) smp1(1'b1);
        push_byte(8'h3C, 0, "R5"); chr(8'h3C, 1'b1);
        push_done(1, "R5");
        eof();
        settle();
        sof(10);
        repeat (25) smp1(1'b1);
        check_active(1'b1, "R5");
        smp1(1'b1);
        check_active(1'b0, "R5");
        settle();

        // R7: end-of-frame with no bytes gives no pulse
        cur_tag = "R7";
        sof(10);
        repeat (3) smp1(1'b1);
        eof();
        check_active(1'b0, "R7");
        settle();

        // R8: malformed character drops the frame silently
        cur_tag = "R8";
        sof(10);
        repeat (3) smp1(1'b1);
        push_byte(8'h11, 0, "R8"); chr(8'h11, 1'b1);
        chr(8'h55, 1'b0);
        check_active(1'b0, "R8");
        settle();
        check_active(1'b0, "R8");

        // R9: frame reaching the byte limit
        cur_tag = "R9";
        sof(10);
        repeat (3) smp1(1'b1);
        for (int i = 0; i < 256; i++) begin
            push_byte((i * 7 + 3) & 8'hFF, i, "R9");
            chr(8'((i * 7 + 3) & 8'hFF), 1'b1);
        end
        check_active(1'b0, "R9");
        settle();

        // R1: reset in the middle of a frame
        cur_tag = "R1";
        sof(10);
        check_active(1'b1, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(frm_active === 1'b0 && byte_stb === 1'b0, "R1", int'(frm_active), 0, "active after mid-frame reset");
        rst_n = 1'b1;
        settle();

        repeat (10) @(negedge clk);
        chk(q_kind.size() == 0, "R6", q_kind.size(), 0, "expected events left unseen");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule